// File: doc/BRIEF.md
# LPC Target SYNC Wait-State Generator

This block answers the SYNC phase of a Low Pin Count bus cycle on the target side. Once the surrounding decoder has settled the cycle type and the host has turned the bus around, it raises `start` for one clock. The generator then drives the 4-bit LAD lines with "wait" SYNC nibbles. The number of wait clocks is fixed for each cycle type. After the wait nibbles it drives one "ready" nibble and pulses `done`, so that the data or turnaround logic can take over.

I/O cycles have one extra feature. If the peripheral's ready line is low once the fixed wait count has run out, the block keeps sending long-wait nibbles. It stops when ready is seen high, or when a total of 330 wait clocks have gone by, which is about 10 µs at 33 MHz. In the timeout case it drives an error nibble and flags a timeout. DMA cycles never stretch. The LAD output enable is active only on clocks that carry a SYNC nibble. A host that asserts the frame strobe (active low) during a cycle drops the block straight back to idle.

Top module: `lpc_sync_gen`

## Requirements
- R1: A cycle with `cyc_kind` = 2'b00 (I/O read) and ready high drives exactly three wait nibbles of 4'b0110 on consecutive clocks. The first of these appears in the clock after `start` is sampled.
- R2: A cycle with `cyc_kind` = 2'b01 (I/O write) and ready high drives exactly two wait nibbles of 4'b0110.
- R3: A cycle with `cyc_kind` = 2'b10 (DMA read) drives three wait nibbles of 4'b0101. A cycle with `cyc_kind` = 2'b11 (DMA write) drives four.
- R4: The last wait nibble is followed by one clock of ready nibble 4'b0000 with `lad_oe` high. In the next clock `done` is high for one clock and `lad_oe` is low.
- R5: In an I/O cycle, ready low at the clock edge that ends the fixed count makes the block keep driving 4'b0110. It continues until the first edge at which ready is sampled high. The ready nibble follows on the next clock.
- R6: Ready has no effect on DMA cycles, and no effect while the fixed wait count is still running. A cycle never shows fewer than its fixed number of wait nibbles.
- R7: If ready is still low after the 330th wait nibble of an I/O cycle, the next clock carries 4'b1010 with `lad_oe` and `timeout` high, and `done` stays low. The block then returns to idle. Ready sampled high at the end of the 330th nibble still gives a normal ready nibble.
- R8: `lad_oe` is high only on clocks that carry a wait, ready or error nibble. While it is low, `lad_out` is 4'b0000.
- R9: `frame_n` low in any clock of an active cycle returns the block to idle at the next edge, with `lad_oe` low. `start` is ignored while `frame_n` is low.
- R10: Synchronous reset puts the block in idle with `lad_oe`, `done` and `timeout` low. A `start` pulse that arrives during an active cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock pulse: decoded cycle is ready for SYNC |
| cyc_kind | input | 2 | 00 I/O read, 01 I/O write, 10 DMA read, 11 DMA write |
| frame_n | input | 1 | Host frame strobe, active low; low aborts the cycle |
| periph_rdy | input | 1 | Peripheral ready, sampled each clock |
| lad_out | output | 4 | SYNC nibble to drive on LAD |
| lad_oe | output | 1 | LAD output enable |
| done | output | 1 | One-clock pulse after the ready nibble |
| timeout | output | 1 | High during the error nibble |

## Verification
The corner cases are at the edges of the wait window. Ready is released exactly at the 330th nibble, which must still give a normal ready nibble. Ready is held low for good, which must produce the error nibble one clock later and no `done`. A limit compare that is off by one would either time out on a peripheral that answered in time or send an extra wait nibble. Ready is also held low during the fixed window and during DMA cycles. A design that stretched too early, or stretched DMA, would change the nibble count or send the wrong code. The bench also aborts with the frame strobe partway through a cycle and sends a second `start` while the block is busy. A design that kept LAD enabled after the abort, or restarted its count on the second pulse, would show up there.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

    typedef enum logic [1:0] {
        K_IO_RD  = 2'b00,
        K_IO_WR  = 2'b01,
        K_DMA_RD = 2'b10,
        K_DMA_WR = 2'b11
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_READY = 3'd2,
        ST_DONE  = 3'd3,
        ST_ERR   = 3'd4
    } sync_st_e;

    localparam logic [3:0] NIB_IO_WAIT  = 4'b0110;
    localparam logic [3:0] NIB_DMA_WAIT = 4'b0101;
    localparam logic [3:0] NIB_READY    = 4'b0000;
    localparam logic [3:0] NIB_ERR      = 4'b1010;

    typedef struct packed {
        logic [3:0] nib;
        logic       oe;
        logic       done;
        logic       tmo;
    } lad_drive_t;

    function automatic logic is_io(cyc_kind_e k);
        return (k == K_IO_RD) || (k == K_IO_WR);
    endfunction

    function automatic logic [3:0] wait_nibble(cyc_kind_e k);
        return is_io(k) ? NIB_IO_WAIT : NIB_DMA_WAIT;
    endfunction

endpackage

// File: rtl/lpc_sync_wcnt.sv
module lpc_sync_wcnt #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] fixed_n,
    input  logic [CW-1:0] limit_n,
    output logic          at_fixed,
    output logic          at_limit
);
    logic [CW-1:0] count;

    // count holds the ordinal of the wait nibble currently on LAD
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (clr)
            count <= CW'(1);
        else if (inc)
            count <= count + CW'(1);
    end

    assign at_fixed = (count >= fixed_n);
    assign at_limit = (count >= limit_n);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        count <= limit_n);

    p_inc_stops_r7: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |-> (count < limit_n));

endmodule

// File: rtl/lpc_sync_fsm.sv
module lpc_sync_fsm
    import lpc_sync_pkg::*;
#(
    parameter int CW        = 9,
    parameter int WAIT_IORD = 3,
    parameter int WAIT_IOWR = 2,
    parameter int WAIT_DMRD = 3,
    parameter int WAIT_DMWR = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  cyc_kind_e     kind_in,
    input  logic          frame_n,
    input  logic          rdy,
    input  logic          at_fixed,
    input  logic          at_limit,
    output sync_st_e      state,
    output cyc_kind_e     kind_q,
    output logic [CW-1:0] fixed_n,
    output logic          cnt_clr,
    output logic          cnt_inc
);
    sync_st_e nxt;

    always_comb begin
        case (kind_q)
            K_IO_RD:  fixed_n = CW'(WAIT_IORD);
            K_IO_WR:  fixed_n = CW'(WAIT_IOWR);
            K_DMA_RD: fixed_n = CW'(WAIT_DMRD);
            default:  fixed_n = CW'(WAIT_DMWR);
        endcase
    end

    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (state != ST_IDLE && !frame_n) begin
            nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start && frame_n) begin
                    nxt     = ST_WAIT;
                    cnt_clr = 1'b1;
                end
                ST_WAIT: begin
                    if (!at_fixed) begin
                        cnt_inc = 1'b1;
                    end else if (is_io(kind_q) && !rdy) begin
                        if (at_limit) nxt = ST_ERR;
                        else          cnt_inc = 1'b1;
                    end else begin
                        nxt = ST_READY;
                    end
                end
                ST_READY: nxt = ST_DONE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind_q <= K_IO_RD;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start && frame_n)
                kind_q <= kind_in;
        end
    end

    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !frame_n) |=> state == ST_IDLE);

    p_min_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && frame_n && !at_fixed) |=> state == ST_WAIT);

    p_dma_no_stretch_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && frame_n && at_fixed && !is_io(kind_q))
        |=> state == ST_READY);

    p_stretch_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && frame_n && at_fixed && is_io(kind_q) && !rdy && !at_limit)
        |=> state == ST_WAIT);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && frame_n) |=> $stable(kind_q));

endmodule

// File: rtl/lpc_sync_enc.sv
module lpc_sync_enc
    import lpc_sync_pkg::*;
(
    input  sync_st_e   state,
    input  cyc_kind_e  kind_q,
    output lad_drive_t drv
);
    always_comb begin
        drv = '0;
        case (state)
            ST_WAIT: begin
                drv.nib = wait_nibble(kind_q);
                drv.oe  = 1'b1;
            end
            ST_READY: begin
                drv.nib = NIB_READY;
                drv.oe  = 1'b1;
            end
            ST_ERR: begin
                drv.nib = NIB_ERR;
                drv.oe  = 1'b1;
                drv.tmo = 1'b1;
            end
            ST_DONE: drv.done = 1'b1;
            default: drv = '0;
        endcase
    end
endmodule

// File: rtl/lpc_sync_gen.sv
module lpc_sync_gen
    import lpc_sync_pkg::*;
#(
    parameter int WAIT_IORD = 3,
    parameter int WAIT_IOWR = 2,
    parameter int WAIT_DMRD = 3,
    parameter int WAIT_DMWR = 4,
    parameter int MAX_SYNC  = 330
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] cyc_kind,
    input  logic       frame_n,
    input  logic       periph_rdy,
    output logic [3:0] lad_out,
    output logic       lad_oe,
    output logic       done,
    output logic       timeout
);
    localparam int CW = $clog2(MAX_SYNC + 1);

    sync_st_e      state;
    cyc_kind_e     kind_q;
    logic [CW-1:0] fixed_n;
    logic          cnt_clr, cnt_inc, at_fixed, at_limit;
    lad_drive_t    drv;

    lpc_sync_fsm #(
        .CW(CW), .WAIT_IORD(WAIT_IORD), .WAIT_IOWR(WAIT_IOWR),
        .WAIT_DMRD(WAIT_DMRD), .WAIT_DMWR(WAIT_DMWR)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .kind_in(cyc_kind_e'(cyc_kind)), .frame_n(frame_n), .rdy(periph_rdy),
        .at_fixed(at_fixed), .at_limit(at_limit),
        .state(state), .kind_q(kind_q), .fixed_n(fixed_n),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
    );

    lpc_sync_wcnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
        .fixed_n(fixed_n), .limit_n(CW'(MAX_SYNC)),
        .at_fixed(at_fixed), .at_limit(at_limit)
    );

    lpc_sync_enc u_enc (
        .state(state), .kind_q(kind_q), .drv(drv)
    );

    assign lad_out = drv.nib;
    assign lad_oe  = drv.oe;
    assign done    = drv.done;
    assign timeout = drv.tmo;

    p_done_after_ready_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(lad_oe) && $past(lad_out) == NIB_READY));

    p_done_released_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !lad_oe);

    p_err_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (timeout && frame_n) |=> (!lad_oe && !done && !timeout));

    p_quiet_lad_r8: assert property (@(posedge clk) disable iff (rst)
        !lad_oe |-> lad_out == 4'b0000);

endmodule

// File: tb/lpc_sync_gen_tb_top.sv
module lpc_sync_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] cyc_kind = 2'b00;
    logic       frame_n = 1'b1;
    logic       periph_rdy = 1'b1;
    logic [3:0] lad_out;
    logic       lad_oe, done, timeout;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lpc_sync_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .cyc_kind(cyc_kind),
        .frame_n(frame_n), .periph_rdy(periph_rdy),
        .lad_out(lad_out), .lad_oe(lad_oe), .done(done), .timeout(timeout)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // hold: wait nibble count after which ready is raised (0 = high from start)
    task automatic run_cycle(input logic [1:0] k, input int hold, input int exp_waits,
                             input bit exp_err, input string req);
        logic [3:0] code;
        int n;
        code = k[1] ? 4'b0101 : 4'b0110;
        periph_rdy = (hold == 0);
        cyc_kind = k;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (lad_oe && lad_out == code && !done && n < 400) begin
            n++;
            if (n == hold) periph_rdy = 1'b1;
            @(negedge clk);
        end
        chk(n == exp_waits, req, "wait nibble count", n, exp_waits);
        if (exp_err) begin
            chk(lad_oe && lad_out == 4'b1010, req, "error nibble", int'(lad_out), 10);
            chk(timeout == 1'b1, req, "timeout flag", int'(timeout), 1);
            @(negedge clk);
            chk(!lad_oe && !done, req, "idle after error (oe,done)", int'({lad_oe, done}), 0);
        end else begin
            chk(lad_oe && lad_out == 4'b0000, "R4", "ready nibble",
                int'({lad_oe, lad_out}), 16);
            chk(!done && !timeout, "R4", "no done on ready clock", int'(done), 0);
            @(negedge clk);
            chk(done && !lad_oe, "R4", "done pulse with oe low",
                int'({done, lad_oe}), 2);
            @(negedge clk);
            chk(!done && !lad_oe, "R8", "idle after done", int'({done, lad_oe}), 0);
        end
        periph_rdy = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(!lad_oe && !done && !timeout && lad_out == 4'b0000, "R10", "reset outputs",
            int'({lad_oe, done, timeout, lad_out}), 0);
    endtask

    task automatic t_fixed_counts();
        run_cycle(2'b00, 0, 3, 1'b0, "R1");
        run_cycle(2'b01, 0, 2, 1'b0, "R2");
        run_cycle(2'b10, 0, 3, 1'b0, "R3");
        run_cycle(2'b11, 0, 4, 1'b0, "R3");
    endtask

    task automatic t_rdy_ignored();
        run_cycle(2'b10, 100000, 3, 1'b0, "R6");
        run_cycle(2'b11, 100000, 4, 1'b0, "R6");
        run_cycle(2'b00, 2, 3, 1'b0, "R6");
        run_cycle(2'b01, 1, 2, 1'b0, "R6");
    endtask

    task automatic t_stretch();
        run_cycle(2'b00, 10, 10, 1'b0, "R5");
        run_cycle(2'b01, 57, 57, 1'b0, "R5");
        run_cycle(2'b00, 330, 330, 1'b0, "R7");
    endtask

    task automatic t_timeout();
        run_cycle(2'b01, 100000, 330, 1'b1, "R7");
        run_cycle(2'b00, 100000, 330, 1'b1, "R7");
    endtask

    task automatic t_abort();
        periph_rdy = 1'b0;
        cyc_kind = 2'b00;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(lad_oe && lad_out == 4'b0110, "R9", "cycle active before abort",
            int'(lad_out), 6);
        @(negedge clk);
        frame_n = 1'b0;
        @(negedge clk);
        chk(!lad_oe && !done, "R9", "LAD released after frame", int'(lad_oe), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!lad_oe, "R9", "start ignored while frame low", int'(lad_oe), 0);
        frame_n = 1'b1;
        periph_rdy = 1'b1;
        @(negedge clk);
        chk(!lad_oe, "R9", "still idle after frame release", int'(lad_oe), 0);
    endtask

    task automatic t_busy_start();
        int n;
        cyc_kind = 2'b01;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cyc_kind = 2'b11;
        n = 0;
        while (lad_oe && lad_out == 4'b0110 && n < 20) begin
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(n == 2, "R10", "restart ignored while busy", n, 2);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_mid_reset();
        periph_rdy = 1'b0;
        cyc_kind = 2'b00;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        do_reset();
        chk(!lad_oe && !timeout, "R10", "reset mid stretch", int'(lad_oe), 0);
        periph_rdy = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_fixed_counts();
        t_rdy_ignored();
        t_stretch();
        t_timeout();
        t_abort();
        t_busy_start();
        t_mid_reset();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

endmodule